// File: doc/BRIEF.md
# Inbound Target Transaction Dispatcher

This block sits behind the target side of a PCI-style bus interface. The bus front end decodes one transaction at a time and hands it over in a single cycle: a 4-bit bus command, an address with a flag that marks a 64-bit (dual-address) access, a write data word and the current bus mode (conventional or PCI-X). The dispatcher classifies the command and picks its handling: posted, delayed or split. It then steers the transaction into one of three internal stores.

The three stores are a paired memory-write queue (an address queue and a data queue that advance together), a single-entry slot for configuration writes, and a read request queue shared by memory and configuration reads. Each stored read carries its handling type, its width flag and a rolling tag, so that a later completion can be matched to it. When the target store has no room, the transaction is dropped and a one-cycle retry pulse tells the front end to retry on the bus. Commands the target does not support raise a one-cycle unsupported pulse instead. The internal-bus side empties each store through a valid/ready port.

Top module: `inbound_dispatch`

## Requirements
- R1: In conventional mode (`pcix_mode`=0), commands 0111 (memory write) and 1111 (memory write and invalidate) are posted: address, dual-address flag and data enter the write pair queue in arrival order.
- R2: In conventional mode, commands 0110, 1100 and 1110 (memory read variants) enter the read queue with `rq_split`=0 (delayed) and `rq_cfg`=0.
- R3: In PCI-X mode (`pcix_mode`=1), commands 0111, 1111 and 1101 are posted into the write pair queue, and commands 0110, 1110 and 1100 enter the read queue with `rq_split`=1.
- R4: Command 1011 (configuration write) goes only to the one-entry delayed-write slot, with `dw_split` equal to `pcix_mode`. The slot's contents stay stable while `dw_valid`=1 and `dw_ready`=0.
- R5: Command 1010 (configuration read) enters the read queue with `rq_cfg`=1 and `rq_split` equal to `pcix_mode`.
- R6: A request whose target is full at the request edge (write pair holding WQ_DEPTH=4 operations, read queue holding RQ_DEPTH=8, or slot occupied) is not stored, and `retry` is high for exactly the next cycle. A pop in the same cycle does not make room for that request.
- R7: The read queue is first-in first-out. Each accepted read gets `rq_tag` equal to the number of reads accepted since reset, modulo 2^TAG_W (TAG_W=3).
- R8: A pop and an accepted push in the same cycle leave `wq_count` or `rq_count` unchanged. With neither, the count holds.
- R9: Any other command (for example 0000, 0001, 0010, 0011, 0100, and 1101 in conventional mode) is stored nowhere, and `unsup` is high for exactly the next cycle.
- R10: The full ADDR_W-bit address and the dual-address flag are kept unchanged in both the write pair and the read queue.
- R11: After reset all counts are 0, `wq_valid`, `rq_valid` and `dw_valid` are 0, and `retry` and `unsup` are 0.
- R12: A stored transaction becomes visible on its dequeue port in the cycle after the request edge. `retry` and `unsup` are registered and appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcix_mode | input | 1 | 1 = PCI-X handling, 0 = conventional |
| req_valid | input | 1 | One decoded target transaction this cycle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | ADDR_W | Transaction address |
| req_dac | input | 1 | Address is a 64-bit dual-address access |
| req_data | input | DATA_W | Write data |
| retry | output | 1 | Previous request dropped, target store full |
| unsup | output | 1 | Previous request carried an unsupported command |
| wq_valid | output | 1 | Write pair head available |
| wq_ready | input | 1 | Pop write pair head |
| wq_addr | output | ADDR_W | Head write address |
| wq_dac | output | 1 | Head write dual-address flag |
| wq_data | output | DATA_W | Head write data |
| wq_count | output | WQ_CW | Operations held in the write pair |
| dw_valid | output | 1 | Configuration write slot occupied |
| dw_ready | input | 1 | Release configuration write slot |
| dw_addr | output | ADDR_W | Configuration write address |
| dw_data | output | DATA_W | Configuration write data |
| dw_split | output | 1 | 1 = split, 0 = delayed |
| rq_valid | output | 1 | Read queue head available |
| rq_ready | input | 1 | Pop read queue head |
| rq_addr | output | ADDR_W | Head read address |
| rq_dac | output | 1 | Head read dual-address flag |
| rq_split | output | 1 | 1 = split, 0 = delayed |
| rq_cfg | output | 1 | 1 = configuration read |
| rq_tag | output | TAG_W | Matching tag of head read |
| rq_count | output | RQ_CW | Entries in the read queue |

## Verification
The hardest case to reach is a read arriving while the read queue is full and the consumer pops in that same cycle. The request must still be refused, and the count must fall by one. The bench fills the queue with eight directed reads, then raises `rq_ready` in the same cycle as a ninth request. It next issues a push together with a pop at depth seven and checks that the count holds. Finally it drains the queue and checks that the tags run in sequence across the refused request.

// File: rtl/ibd_pkg.sv
package ibd_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_MEMWR,
      K_CFGWR,
      K_MEMRD,
      K_CFGRD
   } kind_e;

   typedef enum logic [1:0] {
      H_POSTED,
      H_DELAYED,
      H_SPLIT
   } hand_e;

   localparam logic [3:0] CMD_MRD  = 4'b0110;
   localparam logic [3:0] CMD_MWR  = 4'b0111;
   localparam logic [3:0] CMD_CRD  = 4'b1010;
   localparam logic [3:0] CMD_CWR  = 4'b1011;
   localparam logic [3:0] CMD_MRM  = 4'b1100;
   localparam logic [3:0] CMD_AMWB = 4'b1101;
   localparam logic [3:0] CMD_MRL  = 4'b1110;
   localparam logic [3:0] CMD_MWI  = 4'b1111;

endpackage

// File: rtl/ibd_decode.sv
module ibd_decode
   import ibd_pkg::*;
(
   input  logic [3:0] cmd,
   input  logic       pcix,
   output kind_e      kind,
   output hand_e      hand
);

   hand_e nonpost;

   assign nonpost = pcix ? H_SPLIT : H_DELAYED;

   always_comb begin
      kind = K_NONE;
      hand = H_POSTED;
      case (cmd)
         CMD_MWR, CMD_MWI: begin
            kind = K_MEMWR;
         end
         CMD_AMWB: begin
            if (pcix) kind = K_MEMWR;
         end
         CMD_MRD, CMD_MRM, CMD_MRL: begin
            kind = K_MEMRD;
            hand = nonpost;
         end
         CMD_CRD: begin
            kind = K_CFGRD;
            hand = nonpost;
         end
         CMD_CWR: begin
            kind = K_CFGWR;
            hand = nonpost;
         end
         default: begin
            kind = K_NONE;
         end
      endcase
   end

endmodule

// File: rtl/ibd_fifo.sv
module ibd_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("ibd_fifo: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("ibd_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, empty, push_e, pop_e;

   assign full   = (count == CW'(DEPTH));
   assign empty  = (count == '0);
   assign push_e = push && !full;
   assign pop_e  = pop && !empty;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_e) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_e) wr_ptr <= wr_nxt;
         if (pop_e)  rd_ptr <= rd_nxt;
         case ({push_e, pop_e})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rd_ptr];

endmodule

// File: rtl/ibd_dwslot.sv
module ibd_dwslot #(
   parameter int AW = 64,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   input  logic          split_in,
   output logic          valid,
   input  logic          ready,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic          split
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
      end else if (load && !valid) begin
         valid <= 1'b1;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load && !valid) begin
         addr  <= addr_in;
         data  <= data_in;
         split <= split_in;
      end
   end

endmodule

// File: rtl/inbound_dispatch.sv
module inbound_dispatch
   import ibd_pkg::*;
#(
   parameter  int ADDR_W   = 64,
   parameter  int DATA_W   = 32,
   parameter  int WQ_DEPTH = 4,
   parameter  int RQ_DEPTH = 8,
   parameter  int TAG_W    = 3,
   localparam int WQ_CW    = $clog2(WQ_DEPTH + 1),
   localparam int RQ_CW    = $clog2(RQ_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pcix_mode,
   input  logic              req_valid,
   input  logic [3:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_dac,
   input  logic [DATA_W-1:0] req_data,
   output logic              retry,
   output logic              unsup,
   output logic              wq_valid,
   input  logic              wq_ready,
   output logic [ADDR_W-1:0] wq_addr,
   output logic              wq_dac,
   output logic [DATA_W-1:0] wq_data,
   output logic [WQ_CW-1:0]  wq_count,
   output logic              dw_valid,
   input  logic              dw_ready,
   output logic [ADDR_W-1:0] dw_addr,
   output logic [DATA_W-1:0] dw_data,
   output logic              dw_split,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic [ADDR_W-1:0] rq_addr,
   output logic              rq_dac,
   output logic              rq_split,
   output logic              rq_cfg,
   output logic [TAG_W-1:0]  rq_tag,
   output logic [RQ_CW-1:0]  rq_count
);

   localparam int WA_W = ADDR_W + 1;
   localparam int RE_W = ADDR_W + TAG_W + 3;

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
         $error("inbound_dispatch: ADDR_W must lie in 32..64");
      end
      if ((1 << TAG_W) < RQ_DEPTH) begin : g_bad_tag
         $error("inbound_dispatch: TAG_W too narrow for RQ_DEPTH");
      end
      if (WQ_DEPTH < 1 || RQ_DEPTH < 1) begin : g_bad_depth
         $error("inbound_dispatch: queue depths must be positive");
      end
   endgenerate

   kind_e kind;
   hand_e hand;
   logic  is_read, is_split;
   logic  wq_full, rq_full;
   logic  wq_push, dw_push, rq_push, wq_pop, rq_pop;
   logic  blocked;
   logic [WQ_CW-1:0] wd_count;
   logic [TAG_W-1:0] tag_q;

   ibd_decode u_dec (
      .cmd  (req_cmd),
      .pcix (pcix_mode),
      .kind (kind),
      .hand (hand)
   );

   assign is_read  = (kind == K_MEMRD) || (kind == K_CFGRD);
   assign is_split = (hand == H_SPLIT);

   assign wq_full = (wq_count == WQ_CW'(WQ_DEPTH)) || (wd_count == WQ_CW'(WQ_DEPTH));
   assign rq_full = (rq_count == RQ_CW'(RQ_DEPTH));

   assign wq_push = req_valid && (kind == K_MEMWR) && !wq_full;
   assign dw_push = req_valid && (kind == K_CFGWR) && !dw_valid;
   assign rq_push = req_valid && is_read && !rq_full;

   assign blocked = ((kind == K_MEMWR) && wq_full)
                 || ((kind == K_CFGWR) && dw_valid)
                 || (is_read && rq_full);

   // write pair: address queue and data queue advance together
   assign wq_valid = (wq_count != '0) && (wd_count != '0);
   assign wq_pop   = wq_valid && wq_ready;

   ibd_fifo #(.W(WA_W), .DEPTH(WQ_DEPTH)) u_waq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wq_push),
      .din   ({req_dac, req_addr}),
      .pop   (wq_pop),
      .dout  ({wq_dac, wq_addr}),
      .count (wq_count)
   );

   ibd_fifo #(.W(DATA_W), .DEPTH(WQ_DEPTH)) u_wdq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wq_push),
      .din   (req_data),
      .pop   (wq_pop),
      .dout  (wq_data),
      .count (wd_count)
   );

   ibd_dwslot #(.AW(ADDR_W), .DW(DATA_W)) u_dws (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dw_push),
      .addr_in  (req_addr),
      .data_in  (req_data),
      .split_in (is_split),
      .valid    (dw_valid),
      .ready    (dw_ready),
      .addr     (dw_addr),
      .data     (dw_data),
      .split    (dw_split)
   );

   // read queue entry: {split, cfg, dac, tag, addr}
   assign rq_valid = (rq_count != '0);
   assign rq_pop   = rq_valid && rq_ready;

   ibd_fifo #(.W(RE_W), .DEPTH(RQ_DEPTH)) u_rq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rq_push),
      .din   ({is_split, (kind == K_CFGRD), req_dac, tag_q, req_addr}),
      .pop   (rq_pop),
      .dout  ({rq_split, rq_cfg, rq_dac, rq_tag, rq_addr}),
      .count (rq_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         retry <= 1'b0;
         unsup <= 1'b0;
      end else begin
         if (rq_push) tag_q <= tag_q + 1'b1;
         retry <= req_valid && blocked;
         unsup <= req_valid && (kind == K_NONE);
      end
   end

endmodule

// File: rtl/ibd_checker.sv
module ibd_checker #(
   parameter int ADDR_W   = 64,
   parameter int WQ_DEPTH = 4,
   parameter int RQ_DEPTH = 8,
   parameter int WQ_CW    = 3,
   parameter int RQ_CW    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pcix_mode,
   input logic              req_valid,
   input logic [3:0]        req_cmd,
   input logic              retry,
   input logic              unsup,
   input logic              wq_valid,
   input logic              wq_ready,
   input logic [WQ_CW-1:0]  wq_count,
   input logic              dw_valid,
   input logic              dw_ready,
   input logic [ADDR_W-1:0] dw_addr,
   input logic              rq_valid,
   input logic              rq_ready,
   input logic [RQ_CW-1:0]  rq_count
);

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wq_count) <= WQ_DEPTH) && (int'(rq_count) <= RQ_DEPTH));

   a_r6_full_write_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !pcix_mode && req_cmd == 4'b0111 && int'(wq_count) == WQ_DEPTH)
      |=> retry);

   a_r6_full_read_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 4'b0110 && int'(rq_count) == RQ_DEPTH && !(rq_valid && rq_ready))
      |=> (int'(rq_count) == RQ_DEPTH) && retry);

   a_r8_rq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !(rq_valid && rq_ready)) |=> $stable(rq_count));

   a_r8_wq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !(wq_valid && wq_ready)) |=> $stable(wq_count));

   a_r4_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_valid && !dw_ready) |=> (dw_valid && $stable(dw_addr)));

   a_r9_unsup_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 4'b0000) |=> (unsup && !retry));

endmodule

bind inbound_dispatch ibd_checker #(
   .ADDR_W   (ADDR_W),
   .WQ_DEPTH (WQ_DEPTH),
   .RQ_DEPTH (RQ_DEPTH),
   .WQ_CW    (WQ_CW),
   .RQ_CW    (RQ_CW)
) u_ibd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .pcix_mode (pcix_mode),
   .req_valid (req_valid),
   .req_cmd   (req_cmd),
   .retry     (retry),
   .unsup     (unsup),
   .wq_valid  (wq_valid),
   .wq_ready  (wq_ready),
   .wq_count  (wq_count),
   .dw_valid  (dw_valid),
   .dw_ready  (dw_ready),
   .dw_addr   (dw_addr),
   .rq_valid  (rq_valid),
   .rq_ready  (rq_ready),
   .rq_count  (rq_count)
);

// File: tb/tb_inbound_dispatch.sv
module tb_inbound_dispatch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pcix_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_cmd = '0;
   logic [63:0] req_addr = '0;
   logic        req_dac = 1'b0;
   logic [31:0] req_data = '0;
   logic        wq_ready = 1'b0, dw_ready = 1'b0, rq_ready = 1'b0;
   logic        retry, unsup, wq_valid, wq_dac, dw_valid, dw_split;
   logic        rq_valid, rq_dac, rq_split, rq_cfg;
   logic [63:0] wq_addr, dw_addr, rq_addr;
   logic [31:0] wq_data, dw_data;
   logic [2:0]  wq_count, rq_tag;
   logic [3:0]  rq_count;

   int nchk = 0;
   int nerr = 0;
   int rd_acc = 0;

   always #5 clk = ~clk;

   inbound_dispatch dut (
      .clk(clk), .rst_n(rst_n), .pcix_mode(pcix_mode),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_dac(req_dac), .req_data(req_data),
      .retry(retry), .unsup(unsup),
      .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_addr(wq_addr),
      .wq_dac(wq_dac), .wq_data(wq_data), .wq_count(wq_count),
      .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_addr(dw_addr),
      .dw_data(dw_data), .dw_split(dw_split),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
      .rq_dac(rq_dac), .rq_split(rq_split), .rq_cfg(rq_cfg),
      .rq_tag(rq_tag), .rq_count(rq_count)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one request in one cycle; optionally pop the read queue in that same cycle
   task automatic issue(input logic [3:0] c, input logic [63:0] a, input logic d,
                        input logic [31:0] dt, input logic pop_rd);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_dac = d; req_data = dt;
      rq_ready  = pop_rd;
      @(negedge clk);
      req_valid = 1'b0; rq_ready = 1'b0;
   endtask

   task automatic pop_wq();
      wq_ready = 1'b1; @(negedge clk); wq_ready = 1'b0;
   endtask

   task automatic pop_rq();
      rq_ready = 1'b1; @(negedge clk); rq_ready = 1'b0;
   endtask

   task automatic pop_dw();
      dw_ready = 1'b1; @(negedge clk); dw_ready = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 wq_count", 64'(wq_count), 0);
      check("R11 rq_count", 64'(rq_count), 0);
      check("R11 valids", {wq_valid, dw_valid, rq_valid}, 0);
      check("R11 pulses", {retry, unsup}, 0);
   endtask

   task automatic t_conv_writes();
      pcix_mode = 1'b0;
      issue(4'b0111, 64'h1000, 1'b0, 32'hAAAA_0001, 1'b0);
      check("R12 write visible next cycle", {wq_valid, 2'(wq_count)}, 3'b101);
      issue(4'b1111, 64'h2000, 1'b0, 32'hAAAA_0002, 1'b0);
      check("R1 wq_count", 64'(wq_count), 2);
      check("R1 rq untouched", 64'(rq_count), 0);
      check("R1 head addr", wq_addr, 64'h1000);
      check("R1 head data", 64'(wq_data), 64'hAAAA_0001);
      pop_wq();
      check("R1 second addr", wq_addr, 64'h2000);
      check("R1 second data", 64'(wq_data), 64'hAAAA_0002);
      pop_wq();
      check("R1 drained", 64'(wq_count), 0);
   endtask

   task automatic t_conv_reads();
      int base;
      logic [3:0] cmds [3];
      pcix_mode = 1'b0;
      cmds[0] = 4'b0110; cmds[1] = 4'b1100; cmds[2] = 4'b1110;
      base = rd_acc;
      for (int i = 0; i < 3; i++) begin
         issue(cmds[i], 64'h3000 + 64'(i), 1'b0, 0, 1'b0);
         rd_acc++;
      end
      check("R2 rq_count", 64'(rq_count), 3);
      for (int i = 0; i < 3; i++) begin
         check("R2 delayed mem read", {rq_split, rq_cfg}, 2'b00);
         check("R2 order addr", rq_addr, 64'h3000 + 64'(i));
         check("R7 tag", 64'(rq_tag), 64'((base + i) % 8));
         pop_rq();
      end
   endtask

   task automatic t_pcix();
      int base;
      logic [3:0] w [3];
      logic [3:0] r [3];
      pcix_mode = 1'b1;
      w[0] = 4'b0111; w[1] = 4'b1111; w[2] = 4'b1101;
      r[0] = 4'b0110; r[1] = 4'b1110; r[2] = 4'b1100;
      for (int i = 0; i < 3; i++) issue(w[i], 64'h4000 + 64'(i), 1'b0, 32'(i), 1'b0);
      check("R3 posted writes", 64'(wq_count), 3);
      for (int i = 0; i < 3; i++) begin
         check("R3 write order", wq_addr, 64'h4000 + 64'(i));
         pop_wq();
      end
      base = rd_acc;
      for (int i = 0; i < 3; i++) begin
         issue(r[i], 64'h5000 + 64'(i), 1'b0, 0, 1'b0);
         rd_acc++;
      end
      for (int i = 0; i < 3; i++) begin
         check("R3 split mem read", {rq_split, rq_cfg}, 2'b10);
         check("R7 tag pcix", 64'(rq_tag), 64'((base + i) % 8));
         pop_rq();
      end
      pcix_mode = 1'b0;
   endtask

   task automatic t_cfg();
      pcix_mode = 1'b0;
      issue(4'b1011, 64'h0000_0104, 1'b0, 32'hC0DE_0001, 1'b0);
      check("R4 slot loaded", {dw_valid, dw_split}, 2'b10);
      check("R4 slot addr", dw_addr, 64'h104);
      check("R4 slot data", 64'(dw_data), 64'hC0DE_0001);
      check("R4 not in write queue", 64'(wq_count), 0);
      issue(4'b1011, 64'h0000_0200, 1'b0, 32'hC0DE_0002, 1'b0);
      check("R6 busy slot retry", 64'(retry), 1);
      check("R4 slot held", dw_addr, 64'h104);
      pop_dw();
      check("R4 slot freed", 64'(dw_valid), 0);
      pcix_mode = 1'b1;
      issue(4'b1011, 64'h0000_0300, 1'b0, 32'hC0DE_0003, 1'b0);
      check("R4 split cfg write", {dw_valid, dw_split}, 2'b11);
      pop_dw();
      issue(4'b1010, 64'h0000_0400, 1'b0, 0, 1'b0);
      rd_acc++;
      check("R5 split cfg read", {rq_valid, rq_split, rq_cfg}, 3'b111);
      pop_rq();
      pcix_mode = 1'b0;
      issue(4'b1010, 64'h0000_0500, 1'b0, 0, 1'b0);
      rd_acc++;
      check("R5 delayed cfg read", {rq_valid, rq_split, rq_cfg}, 3'b101);
      pop_rq();
   endtask

   task automatic t_full_write();
      pcix_mode = 1'b0;
      for (int i = 0; i < 4; i++) begin
         issue(4'b0111, 64'h6000 + 64'(i), 1'b0, 32'h100 + 32'(i), 1'b0);
         check("R6 no retry below full", 64'(retry), 0);
      end
      issue(4'b0111, 64'h6FFF, 1'b0, 32'hDEAD, 1'b0);
      check("R6 write full retry", 64'(retry), 1);
      check("R6 write count held", 64'(wq_count), 4);
      @(negedge clk);
      check("R6 retry one cycle", 64'(retry), 0);
      for (int i = 0; i < 4; i++) begin
         check("R1 fifo data order", 64'(wq_data), 64'h100 + 64'(i));
         pop_wq();
      end
      check("R6 dropped write absent", 64'(wq_count), 0);
   endtask

   task automatic t_full_read();
      int base;
      pcix_mode = 1'b0;
      base = rd_acc;
      for (int i = 0; i < 8; i++) begin
         issue(4'b0110, 64'h7000 + 64'(i), 1'b0, 0, 1'b0);
         rd_acc++;
      end
      check("R6 read queue full", 64'(rq_count), 8);
      // full plus same-cycle pop: still refused
      issue(4'b0110, 64'h7FFF, 1'b0, 0, 1'b1);
      check("R6 full read retry with pop", 64'(retry), 1);
      check("R6 count after pop only", 64'(rq_count), 7);
      issue(4'b0110, 64'h7100, 1'b0, 0, 1'b1);
      rd_acc++;
      check("R8 push and pop keep count", 64'(rq_count), 7);
      check("R8 no retry", 64'(retry), 0);
      for (int i = 2; i < 9; i++) begin
         check("R7 tag sequence", 64'(rq_tag), 64'((base + i) % 8));
         pop_rq();
      end
      check("R7 drained", 64'(rq_count), 0);
   endtask

   task automatic t_unsup();
      logic [3:0] bad [5];
      bad[0] = 4'b0000; bad[1] = 4'b0001; bad[2] = 4'b0010;
      bad[3] = 4'b0011; bad[4] = 4'b1101;
      pcix_mode = 1'b0;
      for (int i = 0; i < 5; i++) begin
         issue(bad[i], 64'h8000, 1'b0, 0, 1'b0);
         check("R9 unsup pulse", {unsup, retry}, 2'b10);
         check("R9 nothing stored", {5'(wq_count), 4'(rq_count), dw_valid}, 0);
      end
      pcix_mode = 1'b1;
      issue(4'b0100, 64'h8000, 1'b0, 0, 1'b0);
      check("R9 unsup pcix", 64'(unsup), 1);
      @(negedge clk);
      check("R9 unsup one cycle", 64'(unsup), 0);
      pcix_mode = 1'b0;
   endtask

   task automatic t_dac();
      pcix_mode = 1'b0;
      issue(4'b0111, 64'h1234_5678_9ABC_DEF0, 1'b1, 32'h55, 1'b0);
      check("R10 write dac", 64'(wq_dac), 1);
      check("R10 write addr", wq_addr, 64'h1234_5678_9ABC_DEF0);
      pop_wq();
      issue(4'b1110, 64'hFEDC_BA98_7654_3210, 1'b1, 0, 1'b0);
      rd_acc++;
      check("R10 read dac", 64'(rq_dac), 1);
      check("R10 read addr", rq_addr, 64'hFEDC_BA98_7654_3210);
      pop_rq();
   endtask

   initial begin
      #1_000_000;
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_conv_writes();
      t_conv_reads();
      t_pcix();
      t_cfg();
      t_full_write();
      t_full_read();
      t_unsup();
      t_dac();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule